// File: doc/BRIEF.md
# Control-flow signature watchdog

This block watches the instruction fetches on a processor's memory bus and checks that each straight-line run of instructions (a node, closed by a branch) was fetched exactly as compiled. While a node executes, the block folds every fetched instruction word into a running 16-bit signature. The compiler places a marked signature word just before each node's closing branch. That word carries the expected signature and the node's number. When the word is seen, the block compares the carried value with its own accumulated value and raises a sticky error on a mismatch.

The block also checks the path between nodes. A small table, loaded beforehand, lists for every node up to four nodes that its branch may legally reach. Each signature word names the node just executed, so the block checks that this node appears in the predecessor node's list. A node outside that list raises a separate sticky flow error. The branch unit supplies a one-cycle pulse each time a branch resolves. The first fetch after that pulse opens a new node, and the signature restarts from zero at that fetch.

Top module: `cfsig_watchdog`

## Requirements
- R1: After reset, `sig_err` and `flow_err` are 0, every successor-table entry is invalid, and the first signature word after reset receives no flow check.
- R2: A fetched word whose bits [31:26] equal 6'b111111 is a signature word. It carries the reference signature in bits [15:0] and the node number in bits [19:16], and it is not folded into the accumulator. Every other opcode value is folded in as ordinary code.
- R3: Each ordinary word w updates the signature as follows. First form f = w[31:16] ^ w[15:0]. Then shift the signature left by one bit, XOR it with 16'h1021 if the bit shifted out was 1, and XOR the result with f.
- R4: The first fetch in a cycle strictly after a `branch_done` pulse starts a new node from signature 0. A fetch in the same cycle as `branch_done` still belongs to the node that is closing. The first fetch after reset also starts a node.
- R5: If a signature word's reference differs from the accumulated signature, `sig_err` is 1 from the following cycle and `sig_err_node` holds the word's node number. If the two are equal, neither output changes.
- R6: Once `sig_err` or `flow_err` is set, it stays set until `err_clr`. The node number captured with it does not change, even when later errors occur.
- R7: `err_clr` clears both flags on the next cycle. If an error is detected in the same cycle as `err_clr`, that error sets its flag and its node number is captured.
- R8: A pulse on `tbl_we` writes successor slot `tbl_slot` (0 to 3) of node `tbl_node`, setting its next-node number to `tbl_succ` and its valid bit to `tbl_valid`.
- R9: At each signature word for node v, except the first after reset, if no valid slot of the previous signature word's node holds v, then `flow_err` is 1 from the following cycle and `flow_err_node` is v.
- R10: While `fetch_valid` is 0, `fetch_data` has no effect on the signature, the flags or the node boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | An instruction fetch is on the bus this cycle |
| fetch_data | input | 32 | Fetched instruction word |
| branch_done | input | 1 | Pulse from the branch unit: the current node has closed |
| tbl_we | input | 1 | Successor-table write strobe |
| tbl_node | input | 4 | Node whose successor slot is written |
| tbl_slot | input | 2 | Slot index within that node |
| tbl_succ | input | 4 | Permitted next-node number |
| tbl_valid | input | 1 | Valid bit for the written slot |
| err_clr | input | 1 | Clears both error flags |
| sig_err | output | 1 | Sticky signature-mismatch flag |
| sig_err_node | output | 4 | Node number of the first mismatch |
| flow_err | output | 1 | Sticky illegal-successor flag |
| flow_err_node | output | 4 | Node number of the first illegal entry |

## Verification
On every cycle, the in-line assertions check the following. Both flags hold until cleared. A captured node number stays fixed while its flag is set. A clear without a new error drops both flags. A flag can rise only in the cycle after a signature word, and a flow error never follows the first node after reset. The assertions cannot show that the signature arithmetic is correct, that node boundaries fall on the right fetch, or that table membership decides the flow verdict. The bench shows these through its scenarios: node lengths, deliberately corrupted references, branch pulses that coincide with fetches, ignored bus data, and a sweep over all 256 ordered node pairs against a patterned successor table.

// File: rtl/cfsig_watchdog.sv
module cfsig_watchdog #(
  parameter int DATA_W = 32,
  parameter int SIG_W = 16,
  parameter int ID_W = 4,
  parameter int NSUCC = 4,
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] SIG_OPC = '1,
  parameter bit USE_LFSR = 1'b1,
  parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic              branch_done,
  input  logic              tbl_we,
  input  logic [ID_W-1:0]   tbl_node,
  input  logic [$clog2(NSUCC)-1:0] tbl_slot,
  input  logic [ID_W-1:0]   tbl_succ,
  input  logic              tbl_valid,
  input  logic              err_clr,
  output logic              sig_err,
  output logic [ID_W-1:0]   sig_err_node,
  output logic              flow_err,
  output logic [ID_W-1:0]   flow_err_node
);
  localparam int NNODE  = 1 << ID_W;
  localparam int NCHUNK = DATA_W / SIG_W;

  logic             new_node, prev_valid;
  logic [ID_W-1:0]  prev_id;
  logic [SIG_W-1:0] acc, base, fold, next_acc;
  logic [ID_W-1:0]  succ_id [NNODE][NSUCC];
  logic [NSUCC-1:0] succ_v  [NNODE];
  logic [NSUCC-1:0] hit;

  wire              is_sig  = fetch_valid && fetch_data[DATA_W-1 -: OPC_W] == SIG_OPC;
  wire [SIG_W-1:0]  ref_sig = fetch_data[SIG_W-1:0];
  wire [ID_W-1:0]   ref_id  = fetch_data[SIG_W +: ID_W];

  assign base = new_node ? '0 : acc;

  always_comb begin
    fold = '0;
    for (int i = 0; i < NCHUNK; i++) fold = fold ^ fetch_data[i*SIG_W +: SIG_W];
  end

  generate
    if (USE_LFSR) begin : g_lfsr
      assign next_acc = {base[SIG_W-2:0], 1'b0} ^ (base[SIG_W-1] ? POLY : '0) ^ fold;
    end else begin : g_xor
      assign next_acc = base ^ fold;
    end
  endgenerate

  generate
    for (genvar s = 0; s < NSUCC; s++) begin : g_hit
      assign hit[s] = succ_v[prev_id][s] && succ_id[prev_id][s] == ref_id;
    end
  endgenerate

  wire sig_bad  = is_sig && ref_sig != base;
  wire flow_bad = is_sig && prev_valid && !(|hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      new_node <= 1'b1;
      acc <= '0;
      prev_id <= '0;
      prev_valid <= 1'b0;
    end else begin
      if (fetch_valid) acc <= is_sig ? base : next_acc;
      if (branch_done) new_node <= 1'b1;
      else if (fetch_valid) new_node <= 1'b0;
      if (is_sig) begin
        prev_id <= ref_id;
        prev_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NNODE; n++) succ_v[n] <= '0;
    end else if (tbl_we) begin
      succ_v[tbl_node][tbl_slot] <= tbl_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we) succ_id[tbl_node][tbl_slot] <= tbl_succ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_err <= 1'b0;
      sig_err_node <= '0;
      flow_err <= 1'b0;
      flow_err_node <= '0;
    end else begin
      if (sig_bad) begin
        sig_err <= 1'b1;
        if (!sig_err || err_clr) sig_err_node <= ref_id;
      end else if (err_clr) sig_err <= 1'b0;
      if (flow_bad) begin
        flow_err <= 1'b1;
        if (!flow_err || err_clr) flow_err_node <= ref_id;
      end else if (err_clr) flow_err <= 1'b0;
    end
  end

  // R6
  sig_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err && !err_clr |=> sig_err && $stable(sig_err_node));
  // R6
  flow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_err && !err_clr |=> flow_err && $stable(flow_err_node));
  // R7
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !is_sig |=> !sig_err && !flow_err);
  // R5
  sig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_err && !is_sig |=> !sig_err);
  // R9
  flow_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_err && !(is_sig && prev_valid) |=> !flow_err);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(acc) && $stable(prev_id));
endmodule

// File: tb/cfsig_watchdog_test.sv
`timescale 1ns/1ps
module cfsig_watchdog_test;
  logic clk = 0, rst_n = 0;
  logic fetch_valid = 0, branch_done = 0, tbl_we = 0, tbl_valid = 0, err_clr = 0;
  logic [31:0] fetch_data = 0;
  logic [3:0] tbl_node = 0, tbl_succ = 0;
  logic [1:0] tbl_slot = 0;
  logic sig_err, flow_err;
  logic [3:0] sig_err_node, flow_err_node;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cfsig_watchdog uut (.clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .branch_done(branch_done), .tbl_we(tbl_we), .tbl_node(tbl_node), .tbl_slot(tbl_slot),
    .tbl_succ(tbl_succ), .tbl_valid(tbl_valid), .err_clr(err_clr), .sig_err(sig_err),
    .sig_err_node(sig_err_node), .flow_err(flow_err), .flow_err_node(flow_err_node));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] a, input logic [31:0] w);
    logic [15:0] r;
    r = {a[14:0], 1'b0};
    if (a[15]) r = r ^ 16'h1021;
    return r ^ w[31:16] ^ w[15:0];
  endfunction

  function automatic logic [31:0] gen(input int k);
    logic [31:0] w;
    w = (k + 1) * 32'h9E3779B1 ^ 32'h5A5A1234;
    if (w[31:26] == 6'h3F) w[26] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] sigw(input logic [3:0] id, input logic [15:0] r);
    return {6'h3F, 6'h00, id, r};
  endfunction

  task automatic fetch(input logic [31:0] w, input logic br, input logic clr);
    @(negedge clk);
    fetch_valid = 1; fetch_data = w; branch_done = br; err_clr = clr;
    @(posedge clk); #1;
    fetch_valid = 0; branch_done = 0; err_clr = 0;
  endtask

  task automatic idle(input logic [31:0] junk, input logic br);
    @(negedge clk);
    fetch_data = junk; branch_done = br;
    @(posedge clk); #1;
    branch_done = 0;
  endtask

  task automatic clear();
    @(negedge clk); err_clr = 1;
    @(posedge clk); #1; err_clr = 0;
  endtask

  task automatic wr(input int n, input int s, input int id, input logic v);
    @(negedge clk);
    tbl_we = 1; tbl_node = 4'(n); tbl_slot = 2'(s); tbl_succ = 4'(id); tbl_valid = v;
    @(posedge clk); #1; tbl_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_node(input int id, input int n, input int salt, input logic [15:0] bad, input bit gap);
    logic [15:0] a;
    a = 16'h0;
    for (int i = 0; i < n; i++) begin
      fetch(gen(salt * 7 + i), 0, 0);
      a = step(a, gen(salt * 7 + i));
      if (gap && i == 0) idle(sigw(4'hF, 16'hDEAD), 0);
    end
    fetch(sigw(4'(id), a ^ bad), 0, 0);
    fetch(gen(salt + 99), 1, 0);
    @(negedge clk);
  endtask

  function automatic bit allowed(input int u, input int v);
    for (int s = 0; s < 1 + (u % 4); s++)
      if ((u + 2 * s + 1) % 16 == v) return 1;
    return 0;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 sig_err at reset", sig_err, 0);
    chk("R1 flow_err at reset", flow_err, 0);

    for (int n = 0; n < 8; n++) begin
      run_node(n, n, n + 3, 16'h0, n[0]);
      chk("R3 good signature no error", sig_err, 0);
    end
    for (int b = 0; b < 16; b++) begin
      clear();
      run_node(b, 1 + b % 5, b + 40, 16'(1 << b), 0);
      chk("R5 corrupted signature flagged", sig_err, 1);
      chk("R5 failing node latched", sig_err_node, b);
    end

    clear();
    run_node(6, 3, 70, 16'h0010, 0);
    run_node(2, 2, 71, 16'h0, 0);
    chk("R6 flag stays after good node", sig_err, 1);
    chk("R6 node kept after good node", sig_err_node, 6);
    run_node(9, 2, 72, 16'h8000, 0);
    chk("R6 node kept after second error", sig_err_node, 6);
    clear();
    @(negedge clk);
    chk("R7 clear drops sig_err", sig_err, 0);
    chk("R7 clear drops flow_err", flow_err, 0);
    run_node(3, 2, 73, 16'h0100, 0);
    fetch(gen(1), 0, 0);
    fetch(sigw(4'd12, 16'h1234), 0, 1);
    @(negedge clk);
    chk("R7 error wins over clear", sig_err, 1);
    chk("R7 new node captured on clear", sig_err_node, 12);

    clear();
    fetch(gen(5), 0, 0);
    fetch(gen(6), 1, 0);
    fetch(sigw(4'd1, 16'h0000), 0, 0);
    fetch(gen(7), 1, 0);
    @(negedge clk);
    chk("R4 fetch with branch_done closes node", sig_err, 0);
    clear();
    fetch(gen(5), 0, 0);
    fetch(gen(6), 1, 0);
    fetch(sigw(4'd1, step(step(16'h0, gen(5)), gen(6))), 0, 0);
    fetch(gen(7), 1, 0);
    @(negedge clk);
    chk("R4 new node starts from zero", sig_err, 1);
    clear();
    fetch(gen(8), 0, 0);
    idle(gen(9), 1);
    idle(sigw(4'd7, 16'h0), 0);
    fetch(sigw(4'd2, 16'h0000), 0, 0);
    fetch(gen(10), 1, 0);
    @(negedge clk);
    chk("R4 R10 branch_done alone opens node", sig_err, 0);
    clear();
    fetch(gen(11), 0, 0);
    fetch(sigw(4'd3, step(16'h0, gen(11))), 0, 0);
    fetch(sigw(4'd3, step(16'h0, gen(11))), 0, 0);
    @(negedge clk);
    chk("R2 signature word not accumulated", sig_err, 0);
    fetch(gen(12), 1, 0);
    clear();
    fetch({6'h3E, gen(13)[25:0]}, 0, 0);
    fetch(sigw(4'd4, 16'h0), 0, 0);
    fetch(gen(14), 1, 0);
    @(negedge clk);
    chk("R2 near-signature opcode accumulated", sig_err, 1);

    do_reset();
    run_node(5, 2, 80, 16'h0, 0);
    chk("R1 first node not flow checked", flow_err, 0);
    run_node(9, 2, 81, 16'h0, 0);
    chk("R1 R9 empty table rejects successor", flow_err, 1);
    chk("R9 flow node latched", flow_err_node, 9);

    for (int u = 0; u < 16; u++)
      for (int s = 0; s < 4; s++) begin
        if (s < 1 + (u % 4)) wr(u, s, (u + 2 * s + 1) % 16, 1);
        else wr(u, s, (u + 8) % 16, 0);
      end
    for (int u = 0; u < 16; u++)
      for (int v = 0; v < 16; v++) begin
        run_node(u, 1 + (v % 3), u * 16 + v, 16'h0, 0);
        clear();
        run_node(v, 1 + (u % 3), v * 16 + u + 500, 16'h0, 0);
        chk($sformatf("R8 R9 flow %0d->%0d", u, v), flow_err, !allowed(u, v));
        if (!allowed(u, v)) chk("R9 flow node", flow_err_node, v);
      end
    chk("R3 no signature error during sweep", sig_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule